// File: doc/BRIEF.md
# Paged Memory-Read CRC-16 Sequencer

This block sits beside the byte transmitter of a serial memory-read port and works out the check value that guards each read transfer. The link logic announces every byte it moves with a one-cycle strobe and a class tag: command, low address, high address or data. For data bytes it also gives the memory address of that byte. The block feeds these bytes into a CRC-16 generator. When a block boundary is reached, it raises a request and presents the bit-inverted CRC, one byte at a time, for the transmitter to append.

Two framings are supported, and the mode is captured with each command byte. In whole-memory framing, a single CRC follows the byte at the last implemented address. In paged framing, a CRC follows the last byte of every 8-byte page. The first CRC of a read also covers the command and both address bytes, and the read may start in the middle of a page. Every later CRC starts from a cleared generator and covers only the data of its own page.

Top module: `crc16_read_seq`

## Requirements
- R1: After reset, `crc_req` is 0 and `crc_byte` is 8'h00. `crc_byte` stays 8'h00 whenever `crc_req` is 0.
- R2: The generator uses polynomial x^16+x^15+x^2+1. It shifts the least significant bit first, using reflected taps 16'hA001, from a cleared value of 16'h0000. Command 8'h31, address bytes 8'h32 and 8'h33, then data 8'h34..8'h39 give 16'hBB3D.
- R3: A command strobe (`byte_kind`=2'd0) that arrives while no CRC is pending clears the generator and absorbs the command byte. This also applies in the middle of a read. The address bytes that follow (2'd1 low, 2'd2 high) and the data bytes (2'd3) are then absorbed in arrival order.
- R4: In whole-memory mode, `crc_req` rises in the cycle after the data byte whose address equals MEM_LAST. Page ends before that raise no request.
- R5: In paged mode, `crc_req` rises in the cycle after a data byte whose address has low three bits 3'b111, or whose address equals MEM_LAST.
- R6: The first CRC of a paged read covers the command byte, both address bytes, and the data from the start address (which may be mid-page) to the page end.
- R7: After a CRC has been sent, the generator is cleared. The next page CRC covers only the data bytes of that page.
- R8: While `crc_req` is 1, `crc_byte` first shows the inverted low CRC byte. After one strobe it shows the inverted high byte. After a second strobe `crc_req` falls.
- R9: Strobes taken while `crc_req` is 1 count only as sent CRC bytes. Their class and value do not change the CRC or restart the read.
- R10: Once the CRC for the end of memory has gone out, the block is idle. Non-command strobes are ignored until the next command.
- R11: The framing mode is sampled with the command byte. Later changes of `mode_paged` have no effect until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_paged | input | 1 | 1 = CRC per 8-byte page, 0 = one CRC at end of memory |
| byte_vld | input | 1 | One-cycle strobe: a byte moved on the link |
| byte_kind | input | 2 | Class: 0 command, 1 address low, 2 address high, 3 data |
| byte_val | input | 8 | Value of the strobed byte |
| cur_addr | input | ADDR_W | Memory address of the strobed data byte |
| crc_req | output | 1 | CRC bytes must be appended now |
| crc_byte | output | 8 | Inverted CRC byte to send (low byte first) |

## Verification
The assertions assume that the link presents data bytes with `cur_addr` rising by one per data byte. They assume that reads start with a command byte and then both address bytes. They also assume that, while `crc_req` is high, the transmitter strobes exactly once for each CRC byte it sends. The stimulus tasks walk addresses sequentially from a chosen start. They always answer a pending request with exactly two strobes, and they deliberately give those strobes a command class and odd values. This exercises the case where the class and value must be ignored, without breaking the address ordering the checker relies on.

// File: rtl/crc16_seq_pkg.sv
package crc16_seq_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ALO  = 2'd1,
    KIND_AHI  = 2'd2,
    KIND_DATA = 2'd3
  } byte_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACC     = 2'd1,
    ST_SEND_LO = 2'd2,
    ST_SEND_HI = 2'd3
  } seq_state_t;

  localparam int unsigned CRC_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [CRC_W-1:0] CRC_TAPS = 16'hA001;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter int unsigned W      = 16,
  parameter int unsigned DW     = 8,
  parameter logic [W-1:0] TAPS  = 16'hA001
) (
  input  logic [W-1:0]  crc_in,
  input  logic [DW-1:0] data_in,
  output logic [W-1:0]  crc_out
);
  logic [W-1:0] stage [0:DW];

  assign stage[0] = crc_in;

  // One reflected shift per data bit, least significant bit first.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign stage[i+1] = (stage[i] >> 1) ^
                        ((stage[i][0] ^ data_in[i]) ? TAPS : {W{1'b0}});
  end

  assign crc_out = stage[DW];
endmodule

// File: rtl/crc16_end_detect.sv
module crc16_end_detect #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 3,
  parameter logic [ADDR_W-1:0] MEM_LAST = 16'h07FF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              page_end,
  output logic              mem_end
);
  localparam logic [PAGE_BITS-1:0] PAGE_TOP = {PAGE_BITS{1'b1}};

  assign page_end = (addr[PAGE_BITS-1:0] == PAGE_TOP);
  assign mem_end  = (addr == MEM_LAST);
endmodule

// File: rtl/crc16_tx_sel.sv
module crc16_tx_sel
  import crc16_seq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  seq_state_t     state,
  input  logic [W-1:0]   crc,
  output logic           req,
  output logic [7:0]     tx_byte
);
  always_comb begin
    req     = 1'b0;
    tx_byte = 8'h00;
    case (state)
      ST_SEND_LO: begin
        req     = 1'b1;
        tx_byte = ~crc[7:0];
      end
      ST_SEND_HI: begin
        req     = 1'b1;
        tx_byte = ~crc[15:8];
      end
      default: begin
        req     = 1'b0;
        tx_byte = 8'h00;
      end
    endcase
  end
endmodule

// File: rtl/crc16_read_seq.sv
module crc16_read_seq
  import crc16_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 3,
  parameter logic [ADDR_W-1:0] MEM_LAST = 16'h07FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_paged,
  input  logic              byte_vld,
  input  logic [1:0]        byte_kind,
  input  logic [7:0]        byte_val,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              crc_req,
  output logic [7:0]        crc_byte
);
  // Reset: asynchronous assert, synchronous release.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_t        state_q, state_d;
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic              paged_q, paged_d;
  logic              last_q, last_d;
  logic              ctl_en;

  byte_kind_t        kind;
  logic [CRC_W-1:0]  seed, stepped;
  logic              page_end, mem_end;

  assign kind = byte_kind_t'(byte_kind);
  assign seed = (kind == KIND_CMD) ? {CRC_W{1'b0}} : crc_q;

  crc16_byte_step #(.W(CRC_W), .DW(BYTE_W), .TAPS(CRC_TAPS)) u_step (
    .crc_in  (seed),
    .data_in (byte_val),
    .crc_out (stepped)
  );

  crc16_end_detect #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .MEM_LAST(MEM_LAST)) u_end (
    .addr     (cur_addr),
    .page_end (page_end),
    .mem_end  (mem_end)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    crc_d   = crc_q;
    paged_d = paged_q;
    last_d  = last_q;
    if (byte_vld) begin
      case (state_q)
        ST_IDLE: begin
          if (kind == KIND_CMD) begin
            crc_d   = stepped;
            paged_d = mode_paged;
            last_d  = 1'b0;
            state_d = ST_ACC;
          end
        end
        ST_ACC: begin
          case (kind)
            KIND_CMD: begin
              crc_d   = stepped;
              paged_d = mode_paged;
              last_d  = 1'b0;
            end
            KIND_ALO, KIND_AHI: crc_d = stepped;
            default: begin
              crc_d = stepped;
              if (mem_end) begin
                last_d  = 1'b1;
                state_d = ST_SEND_LO;
              end else if (paged_q && page_end) begin
                state_d = ST_SEND_LO;
              end
            end
          endcase
        end
        ST_SEND_LO: state_d = ST_SEND_HI;
        default: begin
          crc_d   = {CRC_W{1'b0}};
          state_d = last_q ? ST_IDLE : ST_ACC;
        end
      endcase
    end
  end

  assign ctl_en = byte_vld;

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      crc_q   <= {CRC_W{1'b0}};
      paged_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      crc_q   <= crc_d;
      paged_q <= paged_d;
      last_q  <= last_d;
    end
  end

  crc16_tx_sel #(.W(CRC_W)) u_tx (
    .state   (state_q),
    .crc     (crc_q),
    .req     (crc_req),
    .tx_byte (crc_byte)
  );
endmodule

// File: rtl/crc16_read_seq_chk.sv
module crc16_read_seq_chk
  import crc16_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MEM_LAST = 16'h07FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic [1:0]        byte_kind,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              crc_req,
  input logic [7:0]        crc_byte,
  input seq_state_t        state_q,
  input logic [15:0]       crc_q,
  input logic              paged_q
);
  logic data_acc;
  assign data_acc = byte_vld && (state_q == ST_ACC) && (byte_kind == 2'd3);

  p_quiet_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_req |-> (crc_byte == 8'h00));

  p_cmd_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_kind == 2'd0 && !crc_req) |=> (state_q == ST_ACC));

  p_no_page_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !paged_q && cur_addr != MEM_LAST) |=> !crc_req);

  p_mem_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && cur_addr == MEM_LAST) |=> crc_req);

  p_page_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && paged_q && cur_addr[2:0] == 3'b111) |=> crc_req);

  p_clear_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_HI && byte_vld) |=> (crc_q == 16'h0000 && !crc_req));

  p_lo_then_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_LO && byte_vld) |=> (state_q == ST_SEND_HI && crc_req));

  p_hold_crc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND_LO) |=> $stable(crc_q));

  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(byte_vld && byte_kind == 2'd0)) |=> (state_q == ST_IDLE));
endmodule

bind crc16_read_seq crc16_read_seq_chk #(.ADDR_W(ADDR_W), .MEM_LAST(MEM_LAST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_vld  (byte_vld),
  .byte_kind (byte_kind),
  .cur_addr  (cur_addr),
  .crc_req   (crc_req),
  .crc_byte  (crc_byte),
  .state_q   (state_q),
  .crc_q     (crc_q),
  .paged_q   (paged_q)
);

// File: tb/test_crc16_read_seq.sv
module test_crc16_read_seq;
  localparam logic [15:0] LAST = 16'h003F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_paged = 1'b0;
  logic        byte_vld = 1'b0;
  logic [1:0]  byte_kind = 2'd0;
  logic [7:0]  byte_val = 8'h00;
  logic [15:0] cur_addr = 16'h0000;
  logic        crc_req;
  logic [7:0]  crc_byte;

  int total = 0;
  int bad = 0;
  string cur_tag = "R1";

  // Behavioural reference state
  int          m_state = 0;   // 0 idle, 1 collecting, 2 low byte due, 3 high byte due
  logic [15:0] m_crc = 16'h0000;
  bit          m_paged = 1'b0;
  bit          m_done = 1'b0;

  always #5 clk = ~clk;

  crc16_read_seq #(.ADDR_W(16), .PAGE_BITS(3), .MEM_LAST(LAST)) i_crc16_read_seq (
    .clk(clk), .rst_n(rst_n), .mode_paged(mode_paged), .byte_vld(byte_vld),
    .byte_kind(byte_kind), .byte_val(byte_val), .cur_addr(cur_addr),
    .crc_req(crc_req), .crc_byte(crc_byte)
  );

  function automatic logic [15:0] ref_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] != b[i]) r = (r >> 1) ^ 16'hA001;
      else              r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic       er;
    logic [7:0] eb;
    er = (m_state >= 2);
    eb = (m_state == 2) ? ~m_crc[7:0] : (m_state == 3) ? ~m_crc[15:8] : 8'h00;
    chk({cur_tag, " req"}, {15'd0, crc_req}, {15'd0, er});
    chk({cur_tag, " byte"}, {8'd0, crc_byte}, {8'd0, eb});
  endtask

  task automatic model_update(input logic v, input logic [1:0] k, input logic [7:0] d,
                              input logic [15:0] a);
    if (!v) return;
    case (m_state)
      2: m_state = 3;
      3: begin m_crc = 16'h0000; m_state = m_done ? 0 : 1; end
      default: begin
        if (k == 2'd0) begin
          m_crc = ref_upd(16'h0000, d); m_paged = mode_paged; m_done = 1'b0; m_state = 1;
        end else if (m_state == 1) begin
          m_crc = ref_upd(m_crc, d);
          if (k == 2'd3) begin
            if (a == LAST) begin m_done = 1'b1; m_state = 2; end
            else if (m_paged && a[2:0] == 3'b111) m_state = 2;
          end
        end
      end
    endcase
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [7:0] d,
                      input logic [15:0] a);
    @(negedge clk);
    compare_model();
    byte_vld = v; byte_kind = k; byte_val = d; cur_addr = a;
    @(posedge clk);
    model_update(v, k, d, a);
    #1;
    byte_vld = 1'b0;
  endtask

  // Direct look at outputs shortly after the edge that follows a step.
  task automatic peek(input string tag, input logic er, input logic [7:0] eb);
    #1;
    chk({tag, " peek req"}, {15'd0, crc_req}, {15'd0, er});
    chk({tag, " peek byte"}, {8'd0, crc_byte}, {8'd0, eb});
  endtask

  function automatic logic [7:0] dval(input logic [15:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  task automatic start_read(input logic [7:0] cmd, input logic [15:0] a);
    step(1'b1, 2'd0, cmd, 16'h0);
    step(1'b1, 2'd1, a[7:0], 16'h0);
    step(1'b1, 2'd2, a[15:8], 16'h0);
  endtask

  // Two strobes for the CRC bytes, with a command class and junk value (R9).
  task automatic send_crc();
    step(1'b1, 2'd0, 8'hA5, 16'h0);
    step(1'b1, 2'd0, 8'h5A, 16'h0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] e;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    cur_tag = "R1";
    peek("R1", 1'b0, 8'h00);
    step(1'b0, 2'd0, 8'h00, 16'h0);

    // Data before any command is ignored (R10).
    cur_tag = "R10";
    step(1'b1, 2'd3, 8'h11, 16'h0007);
    peek("R10 idle data", 1'b0, 8'h00);

    // Known vector, mid-page start, paged framing (R2, R5, R6, R8).
    cur_tag = "R2";
    mode_paged = 1'b1;
    step(1'b1, 2'd0, 8'h31, 16'h0);
    step(1'b1, 2'd1, 8'h32, 16'h0);
    step(1'b1, 2'd2, 8'h33, 16'h0);
    for (int a = 2; a <= 7; a++) step(1'b1, 2'd3, 8'h32 + 8'(a), 16'(a));
    peek("R2 R6 low", 1'b1, 8'hC2);
    peek("R5 page end", 1'b1, 8'hC2);
    cur_tag = "R8";
    step(1'b1, 2'd0, 8'hA5, 16'h0);
    peek("R8 high", 1'b1, 8'h44);
    step(1'b1, 2'd3, 8'h5A, 16'h0007);
    peek("R8 done", 1'b0, 8'h00);

    // Next page covers only its own data (R7).
    cur_tag = "R7";
    e = 16'h0000;
    for (int a = 8; a <= 15; a++) begin
      e = ref_upd(e, dval(16'(a)));
      step(1'b1, 2'd3, dval(16'(a)), 16'(a));
    end
    peek("R7 low", 1'b1, ~e[7:0]);
    send_crc();

    // Restart mid-read with a new command (R3).
    cur_tag = "R3";
    for (int a = 16; a <= 18; a++) step(1'b1, 2'd3, dval(16'(a)), 16'(a));
    start_read(8'hF0, 16'h0013);
    e = ref_upd(ref_upd(ref_upd(16'h0000, 8'hF0), 8'h13), 8'h00);
    for (int a = 19; a <= 23; a++) begin
      e = ref_upd(e, dval(16'(a)));
      step(1'b1, 2'd3, dval(16'(a)), 16'(a));
    end
    peek("R3 restart", 1'b1, ~e[7:0]);
    cur_tag = "R9";
    send_crc();

    // Whole-memory framing up to MEM_LAST (R4, R10).
    cur_tag = "R4";
    mode_paged = 1'b0;
    start_read(8'hF0, 16'h0030);
    for (int a = 16'h30; a <= 16'h3F; a++) begin
      step(1'b1, 2'd3, dval(16'(a)), 16'(a));
      if (a == 16'h37) peek("R4 no page crc", 1'b0, 8'h00);
    end
    peek("R4 end crc", 1'b1, ~m_crc[7:0]);
    send_crc();
    cur_tag = "R10";
    for (int a = 16'h40; a <= 16'h47; a++) step(1'b1, 2'd3, dval(16'(a)), 16'(a));
    peek("R10 after end", 1'b0, 8'h00);

    // Mode captured at the command only (R11).
    cur_tag = "R11";
    mode_paged = 1'b1;
    start_read(8'hF0, 16'h0000);
    mode_paged = 1'b0;
    for (int a = 0; a <= 7; a++) step(1'b1, 2'd3, dval(16'(a)), 16'(a));
    peek("R11 page end", 1'b1, ~m_crc[7:0]);
    send_crc();

    // Paged read meeting MEM_LAST at a page end, then idle (R5, R10).
    cur_tag = "R5";
    mode_paged = 1'b1;
    start_read(8'hF0, 16'h003C);
    for (int a = 16'h3C; a <= 16'h3F; a++) step(1'b1, 2'd3, dval(16'(a)), 16'(a));
    send_crc();
    cur_tag = "R10";
    step(1'b1, 2'd3, 8'h77, 16'h0007);
    step(1'b0, 2'd0, 8'h00, 16'h0);
    peek("R10 paged end", 1'b0, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule